// File: doc/BRIEF.md
# Read-Sequence Command Detector for a Nonvolatile SRAM

This block sits beside the access decoder of a battery-free nonvolatile SRAM. It watches each chip-enabled access, presented as a one-cycle strobe together with the 11-bit address and a write flag. Whenever it sees a fixed run of six reads in a row at particular addresses, it sends a single-cycle command to the nonvolatile controller. The first five reads form a common prefix. The sixth read selects the command: copy the array into nonvolatile cells (store), or copy the nonvolatile cells back into the array (recall).

Only plain reads take part, so software can issue nonvolatile commands over an ordinary SRAM bus. Any other access that lands in the middle of a run cancels it. A low-supply flag blocks store commands. A busy flag from the controller freezes the detector until the transfer is done.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: After reads of 0x000, 0x555, 0x2AA, 0x7FF and 0x0F0 on five consecutive accepted strobes, a read of 0x70F raises `store_req`. It rises in the cycle after the clock edge that samples that sixth strobe, provided `low_vdd` is 0 on that edge.
- R2: The same five-read prefix followed by a read of 0x70E raises `recall_req` in the cycle after the sixth strobe is sampled.
- R3: A read of 0x39C as the sixth access gives no request and returns the detector to idle. A following read of 0x555 therefore does not continue a run.
- R4: An accepted strobe with `acc_write`=1 cancels any run in progress and returns the detector to idle, whatever its address, including 0x000.
- R5: A read whose address is not the next expected one cancels the run. This includes a second read of the address just matched, and a wrong sixth address.
- R6: A read of 0x000 that cancels a run starts a new run at once, with 0x000 counted as the first step.
- R7: While `low_vdd`=1, a completed store run raises no request and the detector returns to idle. Recall runs are not affected by `low_vdd`.
- R8: While `nv_busy`=1, strobes are ignored: the run state is kept unchanged and no request is raised.
- R9: Each request is high for exactly one cycle, and `store_req` and `recall_req` are never high together.
- R10: With `rst_n` low on a clock edge, the detector returns to idle and both requests are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_stb | input | 1 | One-cycle strobe marking the start of a chip-enabled access |
| acc_addr | input | 11 | Access address, sampled with the strobe |
| acc_write | input | 1 | 1 when the access is a write, sampled with the strobe |
| low_vdd | input | 1 | 1 while the supply is below the switch threshold |
| nv_busy | input | 1 | 1 while a store or recall transfer is running |
| store_req | output | 1 | One-cycle store command |
| recall_req | output | 1 | One-cycle recall command |

## Verification
The bench goes after the abort paths: a repeated read, a write in mid-run, a wrong sixth address, and the reserved test tail 0x39C. A detector that did not reset its step count on these paths would finish a later, partial run and issue a store nobody asked for. The bench also checks the restart-on-0x000 case, where a design without the restart would miss a valid command. Busy strobes placed between steps catch a design that advances or aborts while it should be frozen. A store run under low supply catches a design that either leaks the request or stays armed at step six.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int ADDR_W     = 11;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  localparam logic [ADDR_W-1:0] TAIL_STORE_ADDR  = 11'h70F;
  localparam logic [ADDR_W-1:0] TAIL_RECALL_ADDR = 11'h70E;
  localparam logic [ADDR_W-1:0] TAIL_TEST_ADDR   = 11'h39C;

  typedef enum logic [1:0] {
    TAIL_NONE   = 2'd0,
    TAIL_STORE  = 2'd1,
    TAIL_RECALL = 2'd2,
    TAIL_TEST   = 2'd3
  } tail_e;

  // Address expected at prefix step idx (0-based).
  function automatic logic [ADDR_W-1:0] prefix_addr(input int idx);
    case (idx)
      0:       return 11'h000;
      1:       return 11'h555;
      2:       return 11'h2AA;
      3:       return 11'h7FF;
      default: return 11'h0F0;
    endcase
  endfunction

  function automatic tail_e decode_tail(input logic [ADDR_W-1:0] a);
    if (a == TAIL_STORE_ADDR)       return TAIL_STORE;
    else if (a == TAIL_RECALL_ADDR) return TAIL_RECALL;
    else if (a == TAIL_TEST_ADDR)   return TAIL_TEST;
    else                            return TAIL_NONE;
  endfunction
endpackage

// File: rtl/nvcmd_step_match.sv
module nvcmd_step_match
  import nvcmd_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int PLEN   = PREFIX_LEN,
  parameter int SW     = STEP_W
) (
  input  logic [SW-1:0] step,
  input  logic [AW-1:0] addr,
  output logic          prefix_hit,
  output logic          restart_hit,
  output tail_e         tail
);
  logic [PLEN-1:0] hit_vec;

  genvar gi;
  generate
    for (gi = 0; gi < PLEN; gi++) begin : g_cmp
      assign hit_vec[gi] = (addr == AW'(prefix_addr(gi)));
    end
  endgenerate

  always_comb begin
    prefix_hit = 1'b0;
    for (int i = 0; i < PLEN; i++) begin
      if (step == SW'(i)) prefix_hit = hit_vec[i];
    end
  end

  assign restart_hit = hit_vec[0];
  assign tail        = decode_tail(11'(addr));
endmodule

// File: rtl/nvcmd_seq_fsm.sv
module nvcmd_seq_fsm
  import nvcmd_pkg::*;
#(
  parameter int PLEN = PREFIX_LEN,
  parameter int SW   = STEP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          is_write,
  input  logic          prefix_hit,
  input  logic          restart_hit,
  input  tail_e         tail,
  output logic [SW-1:0] step,
  output logic          fire_store,
  output logic          fire_recall,
  output logic          evt_abort
);
  localparam logic [SW-1:0] LAST = SW'(PLEN);

  logic [SW-1:0] step_q, step_d;
  logic [SW-1:0] abort_step;

  assign abort_step = restart_hit ? SW'(1) : SW'(0);

  always_comb begin
    step_d      = step_q;
    fire_store  = 1'b0;
    fire_recall = 1'b0;
    evt_abort   = 1'b0;
    if (take) begin
      if (is_write) begin
        step_d    = '0;
        evt_abort = 1'b1;
      end else if (step_q == LAST) begin
        case (tail)
          TAIL_STORE:  begin step_d = '0; fire_store  = 1'b1; end
          TAIL_RECALL: begin step_d = '0; fire_recall = 1'b1; end
          TAIL_TEST:   step_d = '0;
          default:     begin step_d = abort_step; evt_abort = 1'b1; end
        endcase
      end else if (prefix_hit) begin
        step_d = step_q + SW'(1);
      end else begin
        step_d    = abort_step;
        evt_abort = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step = step_q;
endmodule

// File: rtl/nvcmd_req_gen.sv
module nvcmd_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_store,
  input  logic fire_recall,
  input  logic low_vdd,
  output logic store_req,
  output logic recall_req
);
  logic store_d;
  assign store_d = fire_store & ~low_vdd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= store_d;
      recall_req <= fire_recall;
    end
  end
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
  import nvcmd_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int PLEN = PREFIX_LEN,
  localparam int SW  = $clog2(PLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_stb,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic          low_vdd,
  input  logic          nv_busy,
  output logic          store_req,
  output logic          recall_req
);
  logic          acc_take;
  logic          prefix_hit;
  logic          restart_hit;
  tail_e         tail;
  logic [SW-1:0] step_q;
  logic          fire_store;
  logic          fire_recall;
  logic          evt_abort;

  assign acc_take = acc_stb & ~nv_busy;

  nvcmd_step_match #(.AW(AW), .PLEN(PLEN), .SW(SW)) i_match (
    .step        (step_q),
    .addr        (acc_addr),
    .prefix_hit  (prefix_hit),
    .restart_hit (restart_hit),
    .tail        (tail)
  );

  nvcmd_seq_fsm #(.PLEN(PLEN), .SW(SW)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (acc_take),
    .is_write    (acc_write),
    .prefix_hit  (prefix_hit),
    .restart_hit (restart_hit),
    .tail        (tail),
    .step        (step_q),
    .fire_store  (fire_store),
    .fire_recall (fire_recall),
    .evt_abort   (evt_abort)
  );

  nvcmd_req_gen i_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_store  (fire_store),
    .fire_recall (fire_recall),
    .low_vdd     (low_vdd),
    .store_req   (store_req),
    .recall_req  (recall_req)
  );
endmodule

// File: rtl/nvcmd_seq_checker.sv
module nvcmd_seq_checker
  import nvcmd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = STEP_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_stb,
  input logic [AW-1:0] acc_addr,
  input logic          acc_write,
  input logic          low_vdd,
  input logic          nv_busy,
  input logic [SW-1:0] step,
  input logic          evt_abort,
  input logic          store_req,
  input logic          recall_req
);
  localparam logic [SW-1:0] LAST = SW'(PREFIX_LEN);

  a_r1_store_cause: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(acc_stb && !nv_busy && !acc_write && step == LAST
                        && acc_addr == AW'(TAIL_STORE_ADDR)));

  a_r2_recall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(acc_stb && !nv_busy && !acc_write && step == LAST
                         && acc_addr == AW'(TAIL_RECALL_ADDR)));

  a_r4_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !nv_busy && acc_write) |=> (step == '0));

  a_r5_abort_resets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> (step <= SW'(1)));

  a_r7_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> !$past(low_vdd));

  a_r8_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> ($stable(step) && !store_req && !recall_req));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |=> (!store_req && !recall_req));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));

  a_r10_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (step == '0 && !store_req && !recall_req));
endmodule

bind nvcmd_seq_detect nvcmd_seq_checker #(.AW(AW), .SW(SW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_stb    (acc_stb),
  .acc_addr   (acc_addr),
  .acc_write  (acc_write),
  .low_vdd    (low_vdd),
  .nv_busy    (nv_busy),
  .step       (step_q),
  .evt_abort  (evt_abort),
  .store_req  (store_req),
  .recall_req (recall_req)
);

// File: tb/test_nvcmd_seq_detect.sv
module test_nvcmd_seq_detect;
  localparam int EXP_NONE = 0, EXP_STORE = 1, EXP_RECALL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0;
  logic [10:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        low_vdd = 1'b0;
  logic        nv_busy = 1'b0;
  logic        store_req, recall_req;

  int checks = 0, failures = 0;
  int    exp_q[$];
  string tag_q[$];
  logic  pend = 1'b0;

  always #10 clk = ~clk;

  nvcmd_seq_detect i_nvcmd_seq_detect (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_addr(acc_addr),
    .acc_write(acc_write), .low_vdd(low_vdd), .nv_busy(nv_busy),
    .store_req(store_req), .recall_req(recall_req)
  );

  function automatic logic [10:0] pfx(input int i);
    case (i)
      0: return 11'h000; 1: return 11'h555; 2: return 11'h2AA;
      3: return 11'h7FF; default: return 11'h0F0;
    endcase
  endfunction

  task automatic report(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual={store,recall}=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: one-cycle strobe, expected outcome queued for the monitor.
  task automatic acc(input logic [10:0] a, input logic w, input int exp, input string tag);
    @(negedge clk);
    acc_stb = 1'b1; acc_addr = a; acc_write = w;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    acc_stb = 1'b0; acc_write = 1'b0;
  endtask

  task automatic prefix(input int n, input string tag);
    for (int i = 0; i < n; i++) acc(pfx(i), 1'b0, EXP_NONE, tag);
  endtask

  always @(posedge clk) pend <= acc_stb;

  // Monitor: compare outputs after each sampled strobe; idle cycles must be quiet.
  always @(negedge clk) begin
    int act;
    act = (store_req === 1'b1 ? 1 : 0) + (recall_req === 1'b1 ? 2 : 0);
    if (pend) begin
      int e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      report(t, act, e);
    end else if (rst_n && (store_req !== 1'b0 || recall_req !== 1'b0)) begin
      report("R9 idle cycle", act, 0);
    end
  end

  initial begin
    #(200000 * 20);
    checks++; failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    report("R10 reset state", {30'd0, recall_req, store_req} == 0 ? 0 : 1, 0);
    rst_n = 1'b1;

    // R1 store
    prefix(5, "R1 prefix"); acc(11'h70F, 1'b0, EXP_STORE, "R1 store");
    // R2 recall
    prefix(5, "R2 prefix"); acc(11'h70E, 1'b0, EXP_RECALL, "R2 recall");
    // R9 back-to-back: store then an immediate strobe gives nothing more
    prefix(5, "R9 prefix"); acc(11'h70F, 1'b0, EXP_STORE, "R9 store");
    acc(11'h000, 1'b0, EXP_NONE, "R9 no repeat pulse");
    acc(11'h123, 1'b0, EXP_NONE, "R9 clear");
    // R3 test tail then continuation must not fire
    prefix(5, "R3 prefix"); acc(11'h39C, 1'b0, EXP_NONE, "R3 test tail");
    for (int i = 1; i < 5; i++) acc(pfx(i), 1'b0, EXP_NONE, "R3 continue");
    acc(11'h70F, 1'b0, EXP_NONE, "R3 idle after test");
    // R5 wrong sixth address
    prefix(5, "R5 prefix"); acc(11'h123, 1'b0, EXP_NONE, "R5 bad tail");
    acc(11'h70F, 1'b0, EXP_NONE, "R5 idle after bad tail");
    // R5 repeated read mid-run
    prefix(2, "R5 prefix"); acc(11'h555, 1'b0, EXP_NONE, "R5 repeat");
    for (int i = 2; i < 5; i++) acc(pfx(i), 1'b0, EXP_NONE, "R5 continue");
    acc(11'h70F, 1'b0, EXP_NONE, "R5 repeat aborted");
    // R4 write at expected address aborts
    prefix(2, "R4 prefix"); acc(11'h2AA, 1'b1, EXP_NONE, "R4 write");
    for (int i = 3; i < 5; i++) acc(pfx(i), 1'b0, EXP_NONE, "R4 continue");
    acc(11'h70F, 1'b0, EXP_NONE, "R4 write aborted");
    // R4 write to 0x000 does not restart
    prefix(2, "R4 prefix"); acc(11'h000, 1'b1, EXP_NONE, "R4 write 000");
    for (int i = 1; i < 5; i++) acc(pfx(i), 1'b0, EXP_NONE, "R4 continue");
    acc(11'h70E, 1'b0, EXP_NONE, "R4 no restart on write");
    // R6 restart on 0x000
    prefix(3, "R6 prefix"); prefix(5, "R6 restarted");
    acc(11'h70E, 1'b0, EXP_RECALL, "R6 recall after restart");
    acc(11'h000, 1'b0, EXP_NONE, "R6 first"); prefix(5, "R6 repeat 000");
    acc(11'h70F, 1'b0, EXP_STORE, "R6 store after repeated 000");
    // R7 low supply
    low_vdd = 1'b1;
    prefix(5, "R7 prefix"); acc(11'h70F, 1'b0, EXP_NONE, "R7 store blocked");
    acc(11'h70F, 1'b0, EXP_NONE, "R7 idle after blocked");
    prefix(5, "R7 prefix"); acc(11'h70E, 1'b0, EXP_RECALL, "R7 recall allowed");
    low_vdd = 1'b0;
    // R8 busy freezes mid-run
    prefix(3, "R8 prefix");
    nv_busy = 1'b1;
    acc(11'h123, 1'b0, EXP_NONE, "R8 busy bad read");
    acc(11'h7FF, 1'b1, EXP_NONE, "R8 busy write");
    acc(11'h7FF, 1'b0, EXP_NONE, "R8 busy good read");
    nv_busy = 1'b0;
    for (int i = 3; i < 5; i++) acc(pfx(i), 1'b0, EXP_NONE, "R8 continue");
    acc(11'h70F, 1'b0, EXP_STORE, "R8 store after busy");
    // R8 full run while busy
    nv_busy = 1'b1;
    prefix(5, "R8 busy prefix"); acc(11'h70F, 1'b0, EXP_NONE, "R8 busy tail");
    nv_busy = 1'b0;
    acc(11'h70F, 1'b0, EXP_NONE, "R8 no step advanced");
    // R10 reset mid-run
    prefix(5, "R10 prefix");
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    acc(11'h70F, 1'b0, EXP_NONE, "R10 idle after reset");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule